// File: doc/BRIEF.md
# Configuration Header Register File with Split Reset Domains

This block holds the 256-byte configuration header of one function in a multifunction bus device. Software reaches it through a dword-addressed port with byte enables. Status logic elsewhere in the chip reaches it through a hardware update port that can only raise status flags. Every stored bit has an access type: read-write, write-one-to-set, or write-one-to-clear with hardware set. Every stored bit also has a reset class.

There are two reset inputs. The global reset is asynchronous and clears every stored bit. The bus reset is synchronous, and its effect depends on the class of each bit. Ordinary bits always clear on a bus reset. Power-management context bits clear on a bus reset only while the wake-event enable bit is 0. Device context bits, such as interrupt routing, ignore the bus reset completely. A few routing bits are shared across functions, so only function 0 may write them.

The read port is combinational. The identity dword is a constant set by a parameter. Offsets that are not implemented read as 0.

Top module: `cfg_space_regs`

## Requirements
- R1: While and after the global reset, every stored bit reads 0, and offset 00h reads the ID_WORD parameter.
- R2: A write changes only the bytes whose enable is 1 (enable bit k covers data bits 8k+7..8k). Read-write fields are: offset 04h bits 7:0; offset 84h bits 19:0; offset A4h bits 1:0, bit 8 and bits 23:16.
- R3: Write-one-to-set fields become 1 where the write data is 1 and stay unchanged where it is 0. These fields are offset 80h bits 23:16 and offset 84h bits 31:24.
- R4: Write-one-to-clear fields become 0 where the write data is 1 and stay unchanged where it is 0. These fields are offset 04h bits 31:24, offset 80h bits 7:0 and offset A4h bit 15.
- R5: A hardware update sets to 1 the write-one-to-clear bits selected in its mask at its dword address, and leaves every other bit alone. If it hits the same bit as a software clear in the same cycle, the bit ends at 1.
- R6: The power-management context bits are offset 80h bits 7:0 and offset A4h bits 8, 15 and 23:16. A bus reset clears them when offset A4h bit 8 (wake-event enable) is 0 and keeps them when that bit is 1.
- R7: The device context bits are all of offset 84h. A bus reset keeps them, and only the global reset clears them.
- R8: A bus reset clears the ordinary bits: offset 04h, offset 80h bits 23:16 and offset A4h bits 1:0.
- R9: Unimplemented offsets and undefined bits read 0. Writes to them and to offset 00h change nothing.
- R10: Offset 84h bits 19:16 are shared across functions. They accept writes only when the FUNC_ID parameter is 0, and read 0 otherwise.
- R11: During a reset cycle, software writes and hardware updates have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| glb_rst | input | 1 | Global reset, asynchronous, active high |
| bus_rst | input | 1 | Bus reset, synchronous, active high |
| acc_addr | input | 6 | Dword index for both read and write |
| acc_wr | input | 1 | Write strobe |
| acc_be | input | 4 | Byte enables |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr (combinational) |
| hw_set_en | input | 1 | Hardware update strobe |
| hw_set_addr | input | 6 | Dword index of the hardware update |
| hw_set_bits | input | 32 | Bits the hardware update sets |

## Verification
Two pairs of events can land in the same cycle, and each pair resolves one way. The first pair is a software write-one-to-clear and a hardware set on the same status bit; the bit must end at 1. The second pair is a bus reset and either a write or a hardware update; the reset must win. The bench drives each pair in a single cycle, sets up the collision on both bits that hit and bits that do not, then reads the dword back. A behavioural model with its own per-bit rules is compared with the read data on every clock. The model also confirms that a bus reset clears context bits only when the wake-event enable, as it stood before that cycle, was 0.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int DW_BITS   = 32;
  localparam int BE_W      = DW_BITS / 8;
  localparam int PM_IDX    = 'h29;
  localparam int PM_EN_BIT = 8;

  typedef struct packed {
    logic [DW_BITS-1:0] rw;
    logic [DW_BITS-1:0] w1s;
    logic [DW_BITS-1:0] w1c;
    logic [DW_BITS-1:0] hwu;
    logic [DW_BITS-1:0] pmectx;
    logic [DW_BITS-1:0] devctx;
    logic [DW_BITS-1:0] glob;
    logic [DW_BITS-1:0] roval;
    logic               impl;
  } dw_attr_t;

  // byte enables widened to a bit mask
  function automatic logic [DW_BITS-1:0] be_to_mask(input logic [BE_W-1:0] be);
    logic [DW_BITS-1:0] m;
    m = '0;
    for (int k = 0; k < BE_W; k++) begin
      m[k*8 +: 8] = {8{be[k]}};
    end
    return m;
  endfunction

  // per-dword bit attributes
  function automatic dw_attr_t dw_attr(input int idx, input logic [DW_BITS-1:0] id_word);
    dw_attr_t a;
    a = '0;
    case (idx)
      'h00: begin
        a.impl  = 1'b1;
        a.roval = id_word;
      end
      'h01: begin
        a.impl = 1'b1;
        a.rw   = 32'h0000_00FF;
        a.w1c  = 32'hFF00_0000;
        a.hwu  = 32'hFF00_0000;
      end
      'h20: begin
        a.impl   = 1'b1;
        a.w1c    = 32'h0000_00FF;
        a.hwu    = 32'h0000_00FF;
        a.pmectx = 32'h0000_00FF;
        a.w1s    = 32'h00FF_0000;
      end
      'h21: begin
        a.impl   = 1'b1;
        a.rw     = 32'h000F_FFFF;
        a.w1s    = 32'hFF00_0000;
        a.devctx = 32'hFF0F_FFFF;
        a.glob   = 32'h000F_0000;
      end
      PM_IDX: begin
        a.impl   = 1'b1;
        a.rw     = 32'h00FF_0103;
        a.w1c    = 32'h0000_8000;
        a.hwu    = 32'h0000_8000;
        a.pmectx = 32'h00FF_8100;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic logic [DW_BITS-1:0] store_mask(input dw_attr_t a);
    return a.rw | a.w1s | a.w1c | a.hwu;
  endfunction

endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfg_space_pkg::*;
#(
  parameter int N_DW = 64,
  localparam int AW  = $clog2(N_DW)
) (
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [BE_W-1:0]    wr_be,
  input  logic               hw_en,
  input  logic [AW-1:0]      hw_addr,
  output logic [N_DW-1:0]    wr_sel,
  output logic [N_DW-1:0]    hw_sel,
  output logic [DW_BITS-1:0] be_mask
);

  for (genvar i = 0; i < N_DW; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_addr == AW'(i));
    assign hw_sel[i] = hw_en && (hw_addr == AW'(i));
  end

  assign be_mask = be_to_mask(wr_be);

endmodule

// File: rtl/cfg_dword.sv
module cfg_dword
  import cfg_space_pkg::*;
#(
  parameter dw_attr_t ATTR    = '0,
  parameter int       FUNC_ID = 0
) (
  input  logic               clk,
  input  logic               glb_rst,
  input  logic               bus_rst,
  input  logic               pme_en,
  input  logic               wr_sel,
  input  logic [DW_BITS-1:0] be_mask,
  input  logic [DW_BITS-1:0] wr_data,
  input  logic               hw_sel,
  input  logic [DW_BITS-1:0] hw_bits,
  output logic [DW_BITS-1:0] rd_word
);

  localparam logic [DW_BITS-1:0] STORE   = store_mask(ATTR);
  localparam logic [DW_BITS-1:0] NORMAL  = STORE & ~ATTR.pmectx & ~ATTR.devctx;
  localparam logic [DW_BITS-1:0] WR_LOCK = (FUNC_ID != 0) ? ATTR.glob : '0;

  logic [DW_BITS-1:0] q;
  logic [DW_BITS-1:0] nxt;
  logic [DW_BITS-1:0] wr_bits;
  logic [DW_BITS-1:0] set_evt;
  logic [DW_BITS-1:0] clr_evt;
  logic [DW_BITS-1:0] hw_evt;
  logic [DW_BITS-1:0] rst_clr;
  logic [DW_BITS-1:0] rw_next;

  always_comb begin
    wr_bits = wr_sel ? (be_mask & ~WR_LOCK) : '0;
    set_evt = wr_bits & wr_data & ATTR.w1s;
    clr_evt = wr_bits & wr_data & ATTR.w1c;
    hw_evt  = hw_sel ? (hw_bits & ATTR.hwu) : '0;
    rst_clr = bus_rst ? (NORMAL | (pme_en ? '0 : ATTR.pmectx)) : '0;
    rw_next = (q & ~(wr_bits & ATTR.rw)) | (wr_data & wr_bits & ATTR.rw);
    if (bus_rst) begin
      nxt = q & ~rst_clr;
    end else begin
      // hardware set applied last: it beats a same-cycle clear
      nxt = ((rw_next | set_evt) & ~clr_evt) | hw_evt;
    end
  end

  always_ff @(posedge clk or posedge glb_rst) begin
    if (glb_rst) q <= '0;
    else         q <= nxt & STORE;
  end

  assign rd_word = q | ATTR.roval;

  assert_w1s_R3: assert property (@(posedge clk) disable iff (glb_rst)
    (!bus_rst && set_evt != '0) |=> ((q & $past(set_evt)) == $past(set_evt)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (glb_rst)
    (!bus_rst) |=> ((q & $past(clr_evt & ~hw_evt)) == '0));

  assert_hw_wins_R5: assert property (@(posedge clk) disable iff (glb_rst)
    (!bus_rst && hw_evt != '0) |=> ((q & $past(hw_evt)) == $past(hw_evt)));

  assert_pme_keep_R6: assert property (@(posedge clk) disable iff (glb_rst)
    (bus_rst && pme_en) |=> ((q & ATTR.pmectx) == ($past(q) & ATTR.pmectx)));

  assert_dev_keep_R7: assert property (@(posedge clk) disable iff (glb_rst)
    bus_rst |=> ((q & ATTR.devctx) == ($past(q) & ATTR.devctx)));

  assert_bus_clear_R8: assert property (@(posedge clk) disable iff (glb_rst)
    bus_rst |=> ((q & NORMAL) == '0));

  assert_rst_no_set_R11: assert property (@(posedge clk) disable iff (glb_rst)
    bus_rst |=> ((q & ~$past(q)) == '0));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_space_pkg::*;
#(
  parameter int N_DW = 64,
  localparam int AW  = $clog2(N_DW)
) (
  input  logic [DW_BITS-1:0] words [N_DW],
  input  logic [AW-1:0]      addr,
  output logic [DW_BITS-1:0] rdata
);

  assign rdata = words[addr];

endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfg_space_pkg::*;
#(
  parameter int           SPACE_BYTES = 256,
  parameter int           FUNC_ID     = 0,
  parameter logic [31:0]  ID_WORD     = 32'h5EC0_0A17,
  localparam int          N_DW        = SPACE_BYTES / 4,
  localparam int          AW          = $clog2(N_DW)
) (
  input  logic              clk,
  input  logic              glb_rst,
  input  logic              bus_rst,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_wr,
  input  logic [BE_W-1:0]   acc_be,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  input  logic              hw_set_en,
  input  logic [AW-1:0]     hw_set_addr,
  input  logic [31:0]       hw_set_bits
);

  logic [N_DW-1:0]    wr_sel;
  logic [N_DW-1:0]    hw_sel;
  logic [DW_BITS-1:0] be_mask;
  logic [DW_BITS-1:0] words [N_DW];
  logic [N_DW-1:0]    impl_vec;
  logic               pme_en;

  cfg_wr_decode #(.N_DW(N_DW)) u_dec (
    .wr_en   (acc_wr),
    .wr_addr (acc_addr),
    .wr_be   (acc_be),
    .hw_en   (hw_set_en),
    .hw_addr (hw_set_addr),
    .wr_sel  (wr_sel),
    .hw_sel  (hw_sel),
    .be_mask (be_mask)
  );

  for (genvar i = 0; i < N_DW; i++) begin : g_dw
    localparam dw_attr_t A = dw_attr(i, ID_WORD);
    assign impl_vec[i] = A.impl;
    if (A.impl) begin : g_impl
      cfg_dword #(.ATTR(A), .FUNC_ID(FUNC_ID)) u_dw (
        .clk     (clk),
        .glb_rst (glb_rst),
        .bus_rst (bus_rst),
        .pme_en  (pme_en),
        .wr_sel  (wr_sel[i]),
        .be_mask (be_mask),
        .wr_data (acc_wdata),
        .hw_sel  (hw_sel[i]),
        .hw_bits (hw_set_bits),
        .rd_word (words[i])
      );
    end else begin : g_hole
      assign words[i] = '0;
    end
  end

  // wake-event enable, as held before this cycle's update
  assign pme_en = words[PM_IDX][PM_EN_BIT];

  cfg_read_mux #(.N_DW(N_DW)) u_rd (
    .words (words),
    .addr  (acc_addr),
    .rdata (acc_rdata)
  );

  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (glb_rst)
    !impl_vec[acc_addr] |-> (acc_rdata == '0));

endmodule

// File: tb/cfg_space_regs_tb.sv
`timescale 1ns/1ps
module cfg_space_regs_tb;

  localparam logic [31:0] ID = 32'h5EC0_0A17;
  localparam int K_NONE = 0, K_RW = 1, K_S = 2, K_UC = 3;
  localparam int C_NORM = 0, C_PME = 1, C_DEV = 2;

  logic        clk = 1'b0;
  logic        glb_rst = 1'b1;
  logic        bus_rst = 1'b0;
  logic [5:0]  acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rdata, rdata_f1;
  logic        hw_set_en = 1'b0;
  logic [5:0]  hw_set_addr = '0;
  logic [31:0] hw_set_bits = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cfg_space_regs #(.FUNC_ID(0), .ID_WORD(ID)) u_dut (
    .clk(clk), .glb_rst(glb_rst), .bus_rst(bus_rst), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(rdata),
    .hw_set_en(hw_set_en), .hw_set_addr(hw_set_addr), .hw_set_bits(hw_set_bits));

  cfg_space_regs #(.FUNC_ID(1), .ID_WORD(ID)) u_dut_f1 (
    .clk(clk), .glb_rst(glb_rst), .bus_rst(bus_rst), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(rdata_f1),
    .hw_set_en(hw_set_en), .hw_set_addr(hw_set_addr), .hw_set_bits(hw_set_bits));

  // ---------------- reference model ----------------
  logic [31:0] m [64];

  function automatic int kind(int idx, int b);
    case (idx)
      'h01: return (b < 8) ? K_RW : (b >= 24) ? K_UC : K_NONE;
      'h20: return (b < 8) ? K_UC : (b >= 16 && b < 24) ? K_S : K_NONE;
      'h21: return (b < 20) ? K_RW : (b >= 24) ? K_S : K_NONE;
      'h29: begin
        if (b < 2 || b == 8 || (b >= 16 && b < 24)) return K_RW;
        if (b == 15) return K_UC;
        return K_NONE;
      end
      default: return K_NONE;
    endcase
  endfunction

  function automatic int cls(int idx, int b);
    if (idx == 'h21) return C_DEV;
    if (idx == 'h20 && b < 8) return C_PME;
    if (idx == 'h29 && (b == 8 || b == 15 || b >= 16)) return C_PME;
    return C_NORM;
  endfunction

  function automatic logic [31:0] mread(int idx);
    return (idx == 0) ? ID : m[idx];
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) m[i] = '0;
  end

  always @(posedge clk) begin
    if (glb_rst) begin
      for (int i = 0; i < 64; i++) m[i] = '0;
    end else if (bus_rst) begin
      bit pe;
      pe = m['h29][8];
      for (int i = 0; i < 64; i++)
        for (int b = 0; b < 32; b++) begin
          if (cls(i, b) == C_NORM) m[i][b] = 1'b0;
          else if (cls(i, b) == C_PME && !pe) m[i][b] = 1'b0;
        end
    end else begin
      if (acc_wr) begin
        for (int b = 0; b < 32; b++) begin
          if (acc_be[b/8]) begin
            case (kind(int'(acc_addr), b))
              K_RW: m[acc_addr][b] = acc_wdata[b];
              K_S:  if (acc_wdata[b]) m[acc_addr][b] = 1'b1;
              K_UC: if (acc_wdata[b]) m[acc_addr][b] = 1'b0;
              default: ;
            endcase
          end
        end
      end
      if (hw_set_en) begin
        for (int b = 0; b < 32; b++)
          if (kind(int'(hw_set_addr), b) == K_UC && hw_set_bits[b])
            m[hw_set_addr][b] = 1'b1;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    n_cmp++;
    if (rdata !== mread(int'(acc_addr))) begin
      n_bad++;
      $display("FAIL model R1-R11 addr %02h: actual %08h expected %08h",
               {acc_addr, 2'b00}, rdata, mread(int'(acc_addr)));
    end
  end

  // ---------------- helpers ----------------
  task automatic cyc(input logic [7:0] off, input bit we, input logic [3:0] be,
                     input logic [31:0] d, input bit he, input logic [7:0] hoff,
                     input logic [31:0] hb, input bit br);
    acc_addr = off[7:2]; acc_wr = we; acc_be = be; acc_wdata = d;
    hw_set_en = he; hw_set_addr = hoff[7:2]; hw_set_bits = hb; bus_rst = br;
    @(posedge clk); @(negedge clk); #1;
    acc_wr = 1'b0; hw_set_en = 1'b0; bus_rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [3:0] be, input logic [31:0] d);
    cyc(off, 1'b1, be, d, 1'b0, 8'h0, '0, 1'b0);
  endtask

  task automatic hw(input logic [7:0] off, input logic [31:0] hb);
    cyc(8'h0, 1'b0, 4'h0, '0, 1'b1, off, hb, 1'b0);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] off, input string tag, input logic [31:0] exp);
    cyc(off, 1'b0, 4'h0, '0, 1'b0, 8'h0, '0, 1'b0);
    check(tag, rdata, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1 id during reset", rdata, ID);
    glb_rst = 1'b0;
    rd(8'h00, "R1 id", ID);
    rd(8'h04, "R1 ctrl zero", 32'h0);
    rd(8'hA4, "R1 pm zero", 32'h0);

    wr(8'h04, 4'b0001, 32'hFFFF_FFFF);
    rd(8'h04, "R2 byte0 only", 32'h0000_00FF);
    wr(8'h04, 4'b0000, 32'h0);
    rd(8'h04, "R2 no enables", 32'h0000_00FF);
    wr(8'h04, 4'b0001, 32'h0000_005A);
    rd(8'h04, "R2 rewrite", 32'h0000_005A);
    wr(8'h84, 4'b0011, 32'h1234_ABCD);
    rd(8'h84, "R2 low half", 32'h0000_ABCD);
    wr(8'h84, 4'b0100, 32'h000F_0000);
    rd(8'h84, "R10 func0 shared", 32'h000F_ABCD);
    check("R10 other func shared", rdata_f1, 32'h0000_ABCD);

    wr(8'h84, 4'b1000, 32'h0300_0000);
    rd(8'h84, "R3 set", 32'h030F_ABCD);
    wr(8'h84, 4'b1000, 32'h0000_0000);
    rd(8'h84, "R3 zero no effect", 32'h030F_ABCD);
    wr(8'h84, 4'b1000, 32'h0C00_0000);
    rd(8'h84, "R3 accumulate", 32'h0F0F_ABCD);

    hw(8'h04, 32'hFF00_00FF);
    rd(8'h04, "R5 hw set", 32'hFF00_005A);
    wr(8'h04, 4'b1000, 32'h0F00_0000);
    rd(8'h04, "R4 clear", 32'hF000_005A);
    cyc(8'h04, 1'b1, 4'b1000, 32'hF000_0000, 1'b1, 8'h04, 32'h3000_0000, 1'b0);
    rd(8'h04, "R5 hw beats clear", 32'h3000_005A);

    wr(8'hA4, 4'b0011, 32'h0000_8103);
    rd(8'hA4, "R4 clear on zero bit", 32'h0000_0103);
    hw(8'hA4, 32'hFFFF_FFFF);
    rd(8'hA4, "R5 hw pm status", 32'h0000_8103);
    wr(8'hA4, 4'b0100, 32'h00AA_0000);
    hw(8'h80, 32'h0000_003C);
    wr(8'h80, 4'b0100, 32'h0011_0000);
    rd(8'h80, "R3 wake set", 32'h0011_003C);

    cyc(8'h00, 1'b0, 4'h0, '0, 1'b0, 8'h0, '0, 1'b1);
    rd(8'h04, "R8 ctrl cleared", 32'h0);
    rd(8'h80, "R6 kept with enable", 32'h0000_003C);
    rd(8'h84, "R7 dev kept", 32'h0F0F_ABCD);
    rd(8'hA4, "R6 pm kept", 32'h00AA_8100);

    wr(8'hA4, 4'b0010, 32'h0);
    rd(8'hA4, "R2 enable off", 32'h00AA_8000);
    cyc(8'h00, 1'b0, 4'h0, '0, 1'b0, 8'h0, '0, 1'b1);
    rd(8'hA4, "R6 pm cleared", 32'h0);
    rd(8'h80, "R6 wake cleared", 32'h0);
    rd(8'h84, "R7 dev kept again", 32'h0F0F_ABCD);

    cyc(8'h04, 1'b1, 4'b0001, 32'h0000_0077, 1'b1, 8'h80, 32'h0000_0001, 1'b1);
    rd(8'h04, "R11 write blocked", 32'h0);
    rd(8'h80, "R11 hw blocked", 32'h0);

    wr(8'h28, 4'b1111, 32'hFFFF_FFFF);
    rd(8'h28, "R9 hole", 32'h0);
    wr(8'h00, 4'b1111, 32'h0);
    rd(8'h00, "R9 id unchanged", ID);
    rd(8'hFC, "R9 top hole", 32'h0);
    rd(8'h84, "R9 others unchanged", 32'h0F0F_ABCD);

    glb_rst = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    glb_rst = 1'b0;
    rd(8'h84, "R7 global clears", 32'h0);
    rd(8'h00, "R1 id after reset", ID);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule